// File: doc/BRIEF.md
# Transmit Sequencer with Response Timeout

This block decides the exact clock cycle in which a single transmission is launched toward the PHY. Software pulses `new_tx` together with a small set of configuration bits. The sequencer then chooses how to defer, using the live state of an external backoff counter and a medium-idle indication. A deferral either waits on a backoff that is already running, or asks for a fresh backoff and waits on that. Before launching, it can also hold until one or both pre-transmit timers report expiry. The launch is a one-cycle pulse.

Once the PHY reports the end of the transmission, the sequencer returns to idle straight away, or, when a response is expected, waits in a response phase. That phase ends when a new reception starts or when a post-transmit timer expires. A one-cycle result code reports which of the two happened. The backoff counter, the timers and the PHY are all outside the block.

Top module: `tx_seq_timeout`

## Requirements
- R1: While `rst_n` is low, or in the cycle after a cycle with `sw_reset` high, the block is idle: `busy`, `tx_start`, `bo_start` and `result_valid` are 0 and `result` is 0. `sw_reset` overrides a simultaneous `new_tx`.
- R2: A `new_tx` pulse seen while idle starts a sequence. `busy` is 1 in every cycle after acceptance until the sequence completes, and 0 while idle.
- R3: On acceptance, the exit is chosen in this priority order. If `cfg_force_bo` is 1, pulse `bo_start` and wait for backoff. Else, if `bo_done` is 0, wait for the running backoff with no `bo_start`. Else, if `medium_idle` is 1, go directly to the pre-transmit wait. Else, pulse `bo_start` and wait for backoff. `bo_start` is a one-cycle pulse in the cycle after acceptance.
- R4: During the backoff wait, `bo_done` is ignored in the cycle in which `bo_start` is high. Otherwise the pre-transmit wait is entered on the first clock edge at which `bo_done` is 1.
- R5: In the pre-transmit wait, the launch is held until `rx1_done` is 1 if `cfg_wait_rx1` was set, and until `tx1_done` is 1 if `cfg_wait_tx1` was set. A disabled wait ignores its flag.
- R6: `tx_start` is high for exactly one cycle: the cycle after the edge at which the pre-transmit condition was met.
- R7: With `cfg_wait_resp` clear, the edge that sees `phy_tx_done` returns the block to idle with `result` = 0 (no timeout configured).
- R8: With `cfg_wait_resp` set, after `phy_tx_done` the block waits. `phy_rx_start` ends the wait with `result` = 1. `resp_tmr_done` alone ends it with `result` = 2. When both are seen at the same edge, `result` = 1.
- R9: `result_valid` is high for exactly one cycle, the first idle cycle after a completed sequence. `result` is 0 whenever `result_valid` is 0, and is never 3.
- R10: `new_tx` while busy is ignored. The configuration bits are captured at acceptance, and changes to them during a sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous return to idle |
| new_tx | input | 1 | Start request pulse |
| cfg_force_bo | input | 1 | Always take a fresh backoff before transmitting |
| cfg_wait_rx1 | input | 1 | Hold launch for the post-receive timer |
| cfg_wait_tx1 | input | 1 | Hold launch for the first post-transmit timer |
| cfg_wait_resp | input | 1 | Wait for a response after transmitting |
| bo_done | input | 1 | Backoff counter is at zero |
| medium_idle | input | 1 | Medium idle for at least the inter-frame space |
| rx1_done | input | 1 | Post-receive timer expired |
| tx1_done | input | 1 | First post-transmit timer expired |
| resp_tmr_done | input | 1 | Response timeout timer expired |
| phy_tx_done | input | 1 | PHY finished transmitting |
| phy_rx_start | input | 1 | PHY detected a new reception |
| tx_start | output | 1 | One-cycle transmit launch |
| bo_start | output | 1 | One-cycle request to start a backoff |
| busy | output | 1 | Sequence in progress |
| result_valid | output | 1 | Result code valid this cycle |
| result | output | 2 | 0 no wait, 1 response began, 2 timed out |

## Verification
Two events can meet at a single edge in the response wait: a reception start and the expiry of the response timer. The sweep includes a mode that raises both on the same cycle, and it requires code 1 in that case, not 2. A second collision is provoked on the backoff path. There, `bo_done` is left high in the cycle in which `bo_start` is issued, which models a counter that has not yet loaded. The launch cycle is judged against the arithmetic schedule, so a sequencer that leaves the backoff wait early is caught by a `tx_start` that arrives too soon.

// File: rtl/tx_seq_timeout.sv
module tx_seq_timeout (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_reset,
  input  logic       new_tx,
  input  logic       cfg_force_bo,
  input  logic       cfg_wait_rx1,
  input  logic       cfg_wait_tx1,
  input  logic       cfg_wait_resp,
  input  logic       bo_done,
  input  logic       medium_idle,
  input  logic       rx1_done,
  input  logic       tx1_done,
  input  logic       resp_tmr_done,
  input  logic       phy_tx_done,
  input  logic       phy_rx_start,
  output logic       tx_start,
  output logic       bo_start,
  output logic       busy,
  output logic       result_valid,
  output logic [1:0] result
);

  localparam logic [1:0] RES_NONE = 2'd0;
  localparam logic [1:0] RES_RX   = 2'd1;
  localparam logic [1:0] RES_TMO  = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_BO, S_PRE, S_TX, S_RESP} st_t;

  st_t  st;
  logic c_rx1, c_tx1, c_resp;
  logic gate_ok, need_bo;

  assign busy    = (st != S_IDLE);
  assign gate_ok = (!c_rx1 || rx1_done) && (!c_tx1 || tx1_done);
  assign need_bo = cfg_force_bo || (bo_done && !medium_idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      c_rx1        <= 1'b0;
      c_tx1        <= 1'b0;
      c_resp       <= 1'b0;
      tx_start     <= 1'b0;
      bo_start     <= 1'b0;
      result_valid <= 1'b0;
      result       <= RES_NONE;
    end else begin
      tx_start     <= 1'b0;
      bo_start     <= 1'b0;
      result_valid <= 1'b0;
      result       <= RES_NONE;
      if (sw_reset) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (new_tx) begin
            c_rx1  <= cfg_wait_rx1;
            c_tx1  <= cfg_wait_tx1;
            c_resp <= cfg_wait_resp;
            if (need_bo) begin
              bo_start <= 1'b1;
              st       <= S_BO;
            end else if (!bo_done) begin
              st <= S_BO;
            end else begin
              st <= S_PRE;
            end
          end
          S_BO: if (bo_done && !bo_start) st <= S_PRE;
          S_PRE: if (gate_ok) begin
            tx_start <= 1'b1;
            st       <= S_TX;
          end
          S_TX: if (phy_tx_done) begin
            if (c_resp) begin
              st <= S_RESP;
            end else begin
              st           <= S_IDLE;
              result_valid <= 1'b1;
              result       <= RES_NONE;
            end
          end
          S_RESP: if (phy_rx_start) begin
            st           <= S_IDLE;
            result_valid <= 1'b1;
            result       <= RES_RX;
          end else if (resp_tmr_done) begin
            st           <= S_IDLE;
            result_valid <= 1'b1;
            result       <= RES_TMO;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/tx_seq_timeout_chk.sv
module tx_seq_timeout_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_reset,
  input logic       new_tx,
  input logic       tx_start,
  input logic       bo_start,
  input logic       busy,
  input logic       result_valid,
  input logic [1:0] result
);

  // R6
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  // R10
  tx_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(busy));

  // R3
  bo_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bo_start |-> ($past(new_tx) && !$past(busy) && !$past(sw_reset)));

  // R1
  sw_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (!busy && !tx_start && !bo_start));

  // R9
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R9
  result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !busy);

  // R9
  result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> (result == 2'd0));

  // R8
  result_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (result != 2'd3));

endmodule

bind tx_seq_timeout tx_seq_timeout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .new_tx(new_tx),
  .tx_start(tx_start), .bo_start(bo_start), .busy(busy),
  .result_valid(result_valid), .result(result)
);

// File: tb/test_tx_seq_timeout.sv
`timescale 1ns/1ps
module test_tx_seq_timeout;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_reset = 1'b0, new_tx = 1'b0;
  logic cfg_force_bo = 1'b0, cfg_wait_rx1 = 1'b0, cfg_wait_tx1 = 1'b0, cfg_wait_resp = 1'b0;
  logic bo_done = 1'b0, medium_idle = 1'b0, rx1_done = 1'b0, tx1_done = 1'b0;
  logic resp_tmr_done = 1'b0, phy_tx_done = 1'b0, phy_rx_start = 1'b0;
  logic tx_start, bo_start, busy, result_valid;
  logic [1:0] result;
  int checks = 0, failures = 0, cyc = 0;

  always #4 clk = ~clk;

  tx_seq_timeout i_tx_seq_timeout (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .new_tx(new_tx),
    .cfg_force_bo(cfg_force_bo), .cfg_wait_rx1(cfg_wait_rx1),
    .cfg_wait_tx1(cfg_wait_tx1), .cfg_wait_resp(cfg_wait_resp),
    .bo_done(bo_done), .medium_idle(medium_idle), .rx1_done(rx1_done),
    .tx1_done(tx1_done), .resp_tmr_done(resp_tmr_done),
    .phy_tx_done(phy_tx_done), .phy_rx_start(phy_rx_start),
    .tx_start(tx_start), .bo_start(bo_start), .busy(busy),
    .result_valid(result_valid), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic clear_inputs();
    sw_reset = 0; new_tx = 0; cfg_force_bo = 0; cfg_wait_rx1 = 0;
    cfg_wait_tx1 = 0; cfg_wait_resp = 0; bo_done = 0; medium_idle = 0;
    rx1_done = 0; tx1_done = 0; resp_tmr_done = 0; phy_tx_done = 0; phy_rx_start = 0;
  endtask

  // mode 0: reception start, 1: timer expiry, 2: both at the same edge
  task automatic run_case(input bit f, input bit bd, input bit mi, input bit wr,
                          input bit wt, input bit wp, input int mode);
    bit bopath, expbo;
    int tpre, fire, fin, code;
    bopath = f || !bd || !mi;
    expbo  = f || (bd && !mi);
    tpre   = bopath ? 4 : 0;
    fire   = tpre + 1;
    if (wr && fire < 6) fire = 6;
    if (wt && fire < 8) fire = 8;
    if (!wp) begin fin = fire + 3; code = 0; end
    else if (mode == 1) begin fin = fire + 6; code = 2; end
    else begin fin = fire + 5; code = 1; end
    for (int k = 0; k <= fire + 10; k++) begin
      @(negedge clk);
      if (k == 0) begin
        chk(busy == 1'b0, "R2 idle before start", busy, 0);
      end else begin
        // R5 R6 R10: launch cycle from the schedule, despite ignored new_tx and flipped config
        chk(tx_start == (k == fire + 1), "R5 R6 R10 tx_start", tx_start, k == fire + 1);
        chk(bo_start == (k == 1 && expbo), "R3 R4 bo_start", bo_start, k == 1 && expbo);
        chk(busy == (k <= fin), "R2 busy", busy, k <= fin);
        chk(result_valid == (k == fin + 1), "R9 result_valid", result_valid, k == fin + 1);
        if (k == fin + 1)
          chk(result == 2'(code), wp ? (mode == 2 ? "R8 both same edge" : "R8 result") : "R7 result",
              result, code);
        else
          chk(result == 2'd0, "R9 result quiet", result, 0);
      end
      new_tx = (k == 0) || (k == fire + 2);
      if (k == 0) begin
        cfg_force_bo = f; cfg_wait_rx1 = wr; cfg_wait_tx1 = wt; cfg_wait_resp = wp;
      end else begin
        cfg_force_bo = !f; cfg_wait_rx1 = !wr; cfg_wait_tx1 = !wt; cfg_wait_resp = !wp;
      end
      if (!bopath) bo_done = 1'b1;
      else if (k == 0) bo_done = bd;
      else if (k == 1) bo_done = bd && expbo;
      else bo_done = (k >= 4);
      medium_idle   = mi;
      rx1_done      = wr && (k >= 6);
      tx1_done      = wt && (k >= 8);
      phy_tx_done   = (k == fire + 3);
      phy_rx_start  = (mode != 1) && (k == fire + 5);
      resp_tmr_done = ((mode == 1) && (k >= fire + 6)) || ((mode == 2) && (k == fire + 5));
    end
    @(negedge clk);
    clear_inputs();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    repeat (3) @(negedge clk);
    // R1: state under asynchronous reset
    chk(busy == 0 && tx_start == 0 && bo_start == 0, "R1 reset outputs", busy, 0);
    chk(result_valid == 0 && result == 0, "R1 reset result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int f = 0; f < 2; f++)
      for (int bd = 0; bd < 2; bd++)
        for (int mi = 0; mi < 2; mi++)
          for (int wr = 0; wr < 2; wr++)
            for (int wt = 0; wt < 2; wt++)
              for (int wp = 0; wp < 2; wp++)
                for (int m = 0; m < 3; m++)
                  run_case(f[0], bd[0], mi[0], wr[0], wt[0], wp[0], m);

    // R1: sw_reset abandons a sequence waiting on backoff
    cfg_force_bo = 1; new_tx = 1;
    @(negedge clk); new_tx = 0;
    @(negedge clk); sw_reset = 1;
    @(negedge clk); sw_reset = 0;
    chk(busy == 0, "R1 sw_reset to idle", busy, 0);
    bo_done = 1; medium_idle = 1; rx1_done = 1; tx1_done = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(tx_start == 0 && busy == 0, "R1 no launch after sw_reset", tx_start, 0);
    end

    // R1: sw_reset beats new_tx at the same edge
    cfg_force_bo = 0; new_tx = 1; sw_reset = 1;
    @(negedge clk); new_tx = 0; sw_reset = 0;
    chk(busy == 0 && bo_start == 0, "R1 sw_reset over new_tx", busy, 0);
    repeat (3) begin
      @(negedge clk);
      chk(tx_start == 0, "R1 no launch after sw_reset", tx_start, 0);
    end
    clear_inputs();
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule